// File: doc/BRIEF.md
# Restartable Vector Memory Element Sequencer

This block walks a unit-stride vector load or store through memory one element at a time. It starts at a given element index and stops at the active vector length. Each element becomes a single memory request. The memory answers every request with an acknowledge and a fault bit. A load element that returns cleanly raises a one-hot register write enable for that element. A store element that returns cleanly is committed by the memory side on the same acknowledge.

When an element faults, the sequencer stops at once and raises a one-cycle trap pulse. It reports the address of the vector instruction and captures the index of the faulting element in its restart-index register. Software reissues the same instruction with that saved index as the start index, and the walk resumes from the faulting element rather than from element zero.

Requests to a region marked idempotent are issued back to back. In a region not marked idempotent, the sequencer leaves one idle cycle after each committed element before it makes the next request.

Top module: `vec_elem_seq`

## Requirements
- R1: An instruction is accepted when `issue_valid` is high and `busy` is low. If its start index is greater than or equal to its vector length, `done` pulses in the next cycle with no memory request and `busy` stays low. Otherwise `busy` rises in the next cycle and stays high until completion or trap.
- R2: When `trap_valid` pulses, `trap_pc` equals the instruction address given at issue, not the address of the next instruction.
- R3: The cycle after a faulting acknowledge, `restart_idx` equals the index of the faulting element. A fault-free completion clears `restart_idx` to 0 in the cycle `done` pulses.
- R4: Every element from the start index up to the faulting index, excluding the faulting index, is committed before the trap. No element at or after the faulting index is committed. `elem_we` carries at most one bit and stays zero on a faulting acknowledge.
- R5: No memory request is made for any element past the faulting one, and `mem_req` is low in the cycle after a faulting acknowledge.
- R6: The first memory request of an instruction carries the start index, so a resumed instruction attempts the saved element first.
- R7: `mem_addr` equals base + index × size, where the `issue_ew` encoding 0, 1, 2, 3 selects 1, 2, 4 or 8 bytes.
- R8: Only one request is outstanding at a time. While `mem_req` is high without `mem_ack`, the request stays high with stable address and index.
- R9: After a clean acknowledge that is not the last element, an idempotent instruction requests the next element in the very next cycle. A non-idempotent instruction holds `mem_req` low for exactly one cycle first.
- R10: `issue_valid` while `busy` is high is ignored and leaves the running instruction, its address and its trap report unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_valid | input | 1 | Offer a new instruction |
| issue_pc | input | PC_W | Instruction address |
| issue_base | input | ADDR_W | Base memory address |
| issue_ew | input | 2 | Element width code: 0=8, 1=16, 2=32, 3=64 bits |
| issue_vl | input | IDX_W | Active vector length |
| issue_start | input | IDX_W | First element index |
| issue_store | input | 1 | 1 = store, 0 = load |
| issue_idem | input | 1 | Target region is idempotent |
| busy | output | 1 | Instruction in flight |
| mem_req | output | 1 | Memory request valid |
| mem_wr | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Element address |
| mem_idx | output | IDX_W | Element index of the request |
| mem_ack | input | 1 | Memory response for the current request |
| mem_fault | input | 1 | Response carries a fault (valid with mem_ack) |
| elem_we | output | MAX_VL | One-hot register write enable for a committed load element |
| done | output | 1 | One-cycle pulse on fault-free completion |
| trap_valid | output | 1 | One-cycle precise trap pulse |
| trap_pc | output | PC_W | Address of the trapping instruction |
| restart_idx | output | IDX_W | Saved restart element index |

## Verification
Loads and stores are run at all four element widths. Fault-free runs are mixed with faults on the start element, on a middle element and on the last element, so that off-by-one errors in the commit range and in the saved index show up separately. A resume from the saved index checks that the faulting element is requested first. A start index equal to the vector length checks the empty-instruction path. Memory latency and the idempotent flag are varied to tell back-to-back pacing apart from gapped pacing and to test that requests stay stable while waiting. An issue offered during a running instruction checks that it cannot disturb the reported trap address.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_GAP  = 2'd2
    } vseq_state_e;
endpackage

// File: rtl/vseq_addr_gen.sv
module vseq_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    input  logic [1:0]        ew,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset = ADDR_W'(idx) << ew;
        addr   = base + offset;
    end
endmodule

// File: rtl/vseq_commit.sv
module vseq_commit #(
    parameter int MAX_VL = 16,
    parameter int IDX_W  = 5
) (
    input  logic              en,
    input  logic [IDX_W-1:0]  idx,
    output logic [MAX_VL-1:0] we
);
    for (genvar g = 0; g < MAX_VL; g++) begin : g_we
        assign we[g] = en && (idx == IDX_W'(g));
    end
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
    import vseq_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int ADDR_W = 32,
    parameter int MAX_VL = 16,
    localparam int IDX_W = $clog2(MAX_VL) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [PC_W-1:0]   issue_pc,
    input  logic [ADDR_W-1:0] issue_base,
    input  logic [1:0]        issue_ew,
    input  logic [IDX_W-1:0]  issue_vl,
    input  logic [IDX_W-1:0]  issue_start,
    input  logic              issue_store,
    input  logic              issue_idem,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [IDX_W-1:0]  mem_idx,
    input  logic              mem_ack,
    input  logic              mem_fault,
    output logic [MAX_VL-1:0] elem_we,
    output logic              done,
    output logic              trap_valid,
    output logic [PC_W-1:0]   trap_pc,
    output logic [IDX_W-1:0]  restart_idx
);
    typedef struct packed {
        vseq_state_e       st;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  vl;
        logic [ADDR_W-1:0] base;
        logic [1:0]        ew;
        logic [PC_W-1:0]   pc;
        logic              store;
        logic              idem;
        logic              done;
        logic              trap;
        logic [PC_W-1:0]   tpc;
        logic [IDX_W-1:0]  ridx;
    } seq_t;

    seq_t q, d;
    logic beat, beat_ok, beat_flt, last_el;

    // Next-state logic
    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.trap   = 1'b0;
        beat     = (q.st == ST_REQ) && mem_ack;
        beat_ok  = beat && !mem_fault;
        beat_flt = beat && mem_fault;
        last_el  = (q.idx + IDX_W'(1)) == q.vl;
        unique case (q.st)
            ST_IDLE: begin
                if (issue_valid) begin
                    d.pc    = issue_pc;
                    d.base  = issue_base;
                    d.ew    = issue_ew;
                    d.vl    = issue_vl;
                    d.store = issue_store;
                    d.idem  = issue_idem;
                    d.idx   = issue_start;
                    if (issue_start >= issue_vl) begin
                        d.done = 1'b1;
                        d.ridx = '0;
                    end else begin
                        d.st = ST_REQ;
                    end
                end
            end
            ST_REQ: begin
                if (beat_flt) begin
                    d.st   = ST_IDLE;
                    d.trap = 1'b1;
                    d.tpc  = q.pc;
                    d.ridx = q.idx;
                end else if (beat_ok) begin
                    if (last_el) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                        d.ridx = '0;
                    end else begin
                        d.idx = q.idx + IDX_W'(1);
                        d.st  = q.idem ? ST_REQ : ST_GAP;
                    end
                end
            end
            ST_GAP:  d.st = ST_REQ;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    vseq_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
        .base (q.base),
        .idx  (q.idx),
        .ew   (q.ew),
        .addr (mem_addr)
    );

    vseq_commit #(.MAX_VL(MAX_VL), .IDX_W(IDX_W)) u_commit (
        .en  (beat_ok && !q.store),
        .idx (q.idx),
        .we  (elem_we)
    );

    assign busy        = (q.st != ST_IDLE);
    assign mem_req     = (q.st == ST_REQ);
    assign mem_wr      = (q.st == ST_REQ) && q.store;
    assign mem_idx     = q.idx;
    assign done        = q.done;
    assign trap_valid  = q.trap;
    assign trap_pc     = q.tpc;
    assign restart_idx = q.ridx;
endmodule

// File: rtl/vseq_checker.sv
module vseq_checker #(
    parameter int PC_W   = 32,
    parameter int ADDR_W = 32,
    parameter int MAX_VL = 16,
    parameter int IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue_valid,
    input logic [PC_W-1:0]   issue_pc,
    input logic [ADDR_W-1:0] issue_base,
    input logic [1:0]        issue_ew,
    input logic [IDX_W-1:0]  issue_vl,
    input logic              issue_idem,
    input logic              busy,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [IDX_W-1:0]  mem_idx,
    input logic              mem_ack,
    input logic              mem_fault,
    input logic [MAX_VL-1:0] elem_we,
    input logic              done,
    input logic              trap_valid,
    input logic [PC_W-1:0]   trap_pc,
    input logic [IDX_W-1:0]  restart_idx
);
    logic [PC_W-1:0]   c_pc;
    logic [ADDR_W-1:0] c_base;
    logic [1:0]        c_ew;
    logic [IDX_W-1:0]  c_vl;
    logic              c_idem;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_pc <= '0; c_base <= '0; c_ew <= '0; c_vl <= '0; c_idem <= 1'b0;
        end else if (issue_valid && !busy) begin
            c_pc <= issue_pc; c_base <= issue_base; c_ew <= issue_ew;
            c_vl <= issue_vl; c_idem <= issue_idem;
        end
    end

    p_trap_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> !busy);
    p_trap_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> trap_pc == c_pc);
    p_fault_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_fault) |=> (trap_valid && restart_idx == $past(mem_idx)));
    p_clear_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> restart_idx == '0);
    p_no_commit_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ack && mem_fault) |-> elem_we == '0);
    p_we_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(elem_we));
    p_stop_after_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_fault) |=> !mem_req);
    p_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr == c_base + (ADDR_W'(mem_idx) << c_ew));
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_idx)));
    p_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !mem_fault && !c_idem) |=> !mem_req);
    p_b2b_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !mem_fault && c_idem && (mem_idx + IDX_W'(1)) != c_vl) |=> mem_req);
endmodule

bind vec_elem_seq vseq_checker #(
    .PC_W(PC_W), .ADDR_W(ADDR_W), .MAX_VL(MAX_VL), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_pc(issue_pc),
    .issue_base(issue_base), .issue_ew(issue_ew), .issue_vl(issue_vl),
    .issue_idem(issue_idem), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_idx(mem_idx), .mem_ack(mem_ack), .mem_fault(mem_fault), .elem_we(elem_we),
    .done(done), .trap_valid(trap_valid), .trap_pc(trap_pc), .restart_idx(restart_idx)
);

// File: tb/tb_vec_elem_seq.sv
module tb_vec_elem_seq;
    localparam int PC_W = 32, ADDR_W = 32, MAX_VL = 16;
    localparam int IDX_W = $clog2(MAX_VL) + 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic issue_valid = 1'b0, issue_store = 1'b0, issue_idem = 1'b0;
    logic [PC_W-1:0] issue_pc = '0;
    logic [ADDR_W-1:0] issue_base = '0;
    logic [1:0] issue_ew = '0;
    logic [IDX_W-1:0] issue_vl = '0, issue_start = '0;
    logic mem_ack = 1'b0, mem_fault = 1'b0;
    logic busy, mem_req, mem_wr, done, trap_valid;
    logic [ADDR_W-1:0] mem_addr;
    logic [IDX_W-1:0] mem_idx, restart_idx;
    logic [MAX_VL-1:0] elem_we;
    logic [PC_W-1:0] trap_pc;

    always #5 clk = ~clk;

    vec_elem_seq #(.PC_W(PC_W), .ADDR_W(ADDR_W), .MAX_VL(MAX_VL)) dut (.*);

    int errors = 0, checks = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge
    int m_phase = 0, m_idx = 0, m_vl = 0, m_ew = 0, m_ridx = 0;
    longint m_base = 0, m_pc = 0, m_tpc = 0;
    bit m_store = 0, m_idem = 0, m_done = 0, m_trap = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_idx = 0; m_ridx = 0; m_tpc = 0; m_done = 0; m_trap = 0;
            m_base = 0; m_ew = 0;
        end else begin
            m_done = 0; m_trap = 0;
            if (m_phase == 0) begin
                if (issue_valid) begin
                    m_pc = issue_pc; m_base = issue_base; m_ew = issue_ew;
                    m_vl = issue_vl; m_store = issue_store; m_idem = issue_idem;
                    m_idx = issue_start;
                    if (int'(issue_start) >= int'(issue_vl)) begin
                        m_done = 1; m_ridx = 0;
                    end else m_phase = 1;
                end
            end else if (m_phase == 1) begin
                if (mem_ack && mem_fault) begin
                    m_trap = 1; m_tpc = m_pc; m_ridx = m_idx; m_phase = 0;
                end else if (mem_ack) begin
                    if (m_idx + 1 == m_vl) begin
                        m_done = 1; m_ridx = 0; m_phase = 0;
                    end else begin
                        m_idx = m_idx + 1;
                        m_phase = m_idem ? 1 : 2;
                    end
                end
            end else m_phase = 1;
        end
    end

    // Memory responder
    int lat = 0, wcnt = 0, fault_at = -1;
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0; mem_fault = 1'b0;
        end else if (mem_req) begin
            if (wcnt >= lat) begin
                mem_ack = 1'b1;
                mem_fault = (fault_at >= 0) && (int'(mem_idx) == fault_at);
                wcnt = 0;
            end else wcnt++;
        end
    end

    // Per-cycle comparison and event capture
    bit loaded[MAX_VL], stored[MAX_VL], requested[MAX_VL];
    int first_req = -1, max_req = -1;
    bit saw_done = 0, saw_trap = 0;
    longint got_tpc = 0;
    int got_ridx = 0;

    always @(negedge clk) begin
        #2;
        if (rst_n && !finished) begin
            longint exp_addr;
            logic [MAX_VL-1:0] exp_we;
            exp_addr = m_base + longint'(m_idx) * (longint'(1) << m_ew);
            exp_we = '0;
            if (m_phase == 1 && mem_ack && !mem_fault && !m_store) exp_we[m_idx] = 1'b1;
            chk(busy == (m_phase != 0), "R1 R10 busy", busy, m_phase != 0);
            chk(mem_req == (m_phase == 1), "R8 R9 mem_req", mem_req, m_phase == 1);
            chk(done == m_done, "R1 done", done, m_done);
            chk(trap_valid == m_trap, "R5 trap_valid", trap_valid, m_trap);
            chk(trap_pc == PC_W'(m_tpc), "R2 trap_pc", trap_pc, m_tpc);
            chk(int'(restart_idx) == m_ridx, "R3 restart_idx", restart_idx, m_ridx);
            chk(elem_we == exp_we, "R4 elem_we", elem_we, exp_we);
            if (m_phase == 1) begin
                chk(mem_addr == ADDR_W'(exp_addr), "R7 mem_addr", mem_addr, exp_addr);
                chk(int'(mem_idx) == m_idx, "R6 mem_idx", mem_idx, m_idx);
                chk(mem_wr == m_store, "R7 mem_wr", mem_wr, m_store);
            end
            if (mem_req) begin
                if (first_req < 0) first_req = mem_idx;
                if (int'(mem_idx) > max_req) max_req = mem_idx;
                requested[mem_idx] = 1'b1;
            end
            for (int i = 0; i < MAX_VL; i++) if (elem_we[i]) loaded[i] = 1'b1;
            if (mem_req && mem_wr && mem_ack && !mem_fault) stored[mem_idx] = 1'b1;
            if (done) saw_done = 1;
            if (trap_valid) begin saw_trap = 1; got_tpc = trap_pc; got_ridx = restart_idx; end
        end
    end

    task automatic run(input longint pc, input longint base, input int ew, input int vl,
                       input int start, input bit st, input bit idem, input int l,
                       input int f, input bit poke);
        for (int i = 0; i < MAX_VL; i++) begin loaded[i] = 0; stored[i] = 0; requested[i] = 0; end
        first_req = -1; max_req = -1; saw_done = 0; saw_trap = 0;
        lat = l; fault_at = f; wcnt = 0;
        @(negedge clk);
        issue_valid = 1'b1; issue_pc = PC_W'(pc); issue_base = ADDR_W'(base);
        issue_ew = 2'(ew); issue_vl = IDX_W'(vl); issue_start = IDX_W'(start);
        issue_store = st; issue_idem = idem;
        @(negedge clk);
        issue_valid = 1'b0;
        if (poke) begin
            @(negedge clk);
            issue_valid = 1'b1; issue_pc = PC_W'(pc + 'h40); issue_start = '0;
            @(negedge clk);
            issue_valid = 1'b0;
        end
        for (int n = 0; n < 400 && !saw_done && !saw_trap; n++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic commit_range(input int lo, input int hi, input bit st, input string tag);
        bit ok = 1;
        for (int i = 0; i < MAX_VL; i++) begin
            bit exp = (i >= lo) && (i < hi);
            if ((st ? stored[i] : loaded[i]) != exp) ok = 0;
        end
        chk(ok, tag, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0 && mem_req == 0 && restart_idx == 0 && trap_valid == 0 && elem_we == 0,
            "R1 reset state", {busy, mem_req, trap_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Clean idempotent byte load
        run('h1000, 'h8000, 0, 8, 0, 0, 1, 0, -1, 0);
        chk(saw_done && !saw_trap, "R1 clean load completes", saw_done, 1);
        commit_range(0, 8, 0, "R4 all loads committed");
        chk(restart_idx == 0, "R3 cleared after completion", restart_idx, 0);

        // Non-idempotent word store, fault at 3, issue poked mid-flight
        run('h2004, 'h9000, 2, 10, 0, 1, 0, 2, 3, 1);
        chk(saw_trap, "R5 store trap taken", saw_trap, 1);
        chk(got_tpc == 'h2004, "R2 trap pc is instruction address", got_tpc, 'h2004);
        chk(got_tpc == 'h2004, "R10 busy issue ignored", got_tpc, 'h2004);
        chk(got_ridx == 3, "R3 faulting index saved", got_ridx, 3);
        commit_range(0, 3, 1, "R4 stores below fault only");
        chk(max_req == 3, "R5 no request past fault", max_req, 3);

        // Resume from saved index
        run('h2004, 'h9000, 2, 10, got_ridx, 1, 0, 1, -1, 0);
        chk(first_req == 3, "R6 saved element attempted first", first_req, 3);
        commit_range(3, 10, 1, "R4 resumed stores");
        chk(saw_done && restart_idx == 0, "R3 cleared on resume completion", restart_idx, 0);

        // Empty instruction
        run('h3000, 'hA000, 1, 5, 5, 0, 0, 0, -1, 0);
        chk(saw_done && first_req == -1, "R1 start equal vl no access", first_req, -1);

        // Fault on the start element, doubleword load
        run('h4008, 'hB000, 3, 4, 2, 0, 1, 1, 2, 0);
        chk(saw_trap && got_ridx == 2, "R3 fault on start element", got_ridx, 2);
        commit_range(0, 0, 0, "R4 nothing committed");

        // Fault on the last element, halfword load
        run('h500C, 'hC002, 1, 6, 0, 0, 1, 0, 5, 0);
        chk(saw_trap && got_ridx == 5, "R3 fault on last element", got_ridx, 5);
        commit_range(0, 5, 0, "R4 loads below last");
        chk(got_tpc == 'h500C, "R2 trap pc last", got_tpc, 'h500C);

        // Clean non-idempotent halfword store, full length
        run('h6000, 'hD000, 1, 16, 0, 1, 0, 0, -1, 0);
        commit_range(0, 16, 1, "R9 gapped stores all commit");

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule